// File: doc/BRIEF.md
# Staged Power-Domain Wakeup Sequencer

This block brings one switchable power domain back up after a wakeup request, with no software stepping. It first closes a small group of power switches, which limits inrush current. After a programmed wait it closes the large remaining group. Then, depending on the selected mode, it either powers the domain's memory groups one after another or has them come up together with the logic. Finally it issues a wakeup reset pulse, and it reports completion.

The wait for each stage is the product of a stable-count input and an oscillator-frequency prescale input. Both are counted in cycles of the block's clock. A per-module retention flag vector keeps the wakeup reset away from modules that hold their state across power-off, while modules with ordinary flip-flops receive it. A power-down request, accepted only once the domain is fully on, drops every enable in one cycle.

Top module: `pd_wake_seq`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), all outputs are 0 and the block waits for a wakeup request. A reset in the middle of a sequence also clears every output at that edge.
- R2: A `wake_req` sampled high while the block is idle sets `sw_small_en` at that same edge. `sw_large_en` is never high unless `sw_small_en` is high.
- R3: Every stage lasts D clock cycles, where D = max(`stable_cnt`,1) × max(`osc_freq`,1). `sw_large_en` rises D edges after `sw_small_en`.
- R4: In full mode (`mode_simul`=0, sampled with the wakeup request), `mem_en` stays 0 through both switch stages. It then gains one bit from bit 0 upward every D cycles, so `mem_en` is always a thermometer code, and it reaches all ones after N_MEM steps.
- R5: In simultaneous mode (`mode_simul`=1), every `mem_en` bit rises at the same edge as `sw_small_en`, and no memory steps are taken.
- R6: When the last power stage ends, `mod_rst[i]` = NOT `retain[i]` for exactly RST_W cycles. A module whose `retain` bit is 1 never sees its reset bit high.
- R7: `done` rises at the edge that ends the reset pulse. While `done` is high, both switch enables and all `mem_en` bits are 1 and `mod_rst` is 0. Latency from the wake edge is (2+N_MEM)·D+RST_W in full mode and 2·D+RST_W in simultaneous mode.
- R8: A `pwr_down_req` sampled while `done` is high clears `sw_small_en`, `sw_large_en`, `mem_en`, `mod_rst` and `done` at that edge.
- R9: `wake_req` is ignored while a sequence runs or the domain is on, and `pwr_down_req` is ignored before `done`. Neither changes any output or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Wakeup event |
| pwr_down_req | input | 1 | Request to switch the domain off |
| mode_simul | input | 1 | 1: memories with logic; 0: memories one group at a time |
| osc_freq | input | FREQ_W (4) | Oscillator prescale factor, 0 treated as 1 |
| stable_cnt | input | CNT_W (8) | Power-stable count, 0 treated as 1 |
| retain | input | N_MOD (4) | Per-module retention flag |
| sw_small_en | output | 1 | Enable of the small switch group |
| sw_large_en | output | 1 | Enable of the large switch group |
| mem_en | output | N_MEM (4) | Memory group enables, thermometer coded |
| mod_rst | output | N_MOD (4) | Wakeup reset per module, active high |
| done | output | 1 | Domain fully powered |

## Verification
Every output is a register loaded from the next state. So each result appears at the clock edge that samples its cause, and a stimulus sampled at edge E shows at the outputs right after E. The bench drives the wake pulse on a falling edge and counts j edges from the sampling edge. At each later falling edge it compares each output with its due value for that j: `sw_large_en` from j=D, memory bit k from j=(3+k)·D, the reset from the last stage end for RST_W cycles, and `done` at the tabulated latency. Power-down and reset effects are checked one falling edge after the edge that samples them.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;
  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_SW1  = 3'd1,
    PS_SW2  = 3'd2,
    PS_MEM  = 3'd3,
    PS_RST  = 3'd4,
    PS_ON   = 3'd5
  } pwr_state_t;
endpackage

// File: rtl/pd_stage_timer.sv
module pd_stage_timer #(
  parameter int FREQ_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [FREQ_W-1:0] osc_freq,
  input  logic [CNT_W-1:0]  stable_cnt,
  output logic              hit
);
  localparam int DW = CNT_W + FREQ_W;

  logic [FREQ_W-1:0] eff_f;
  logic [CNT_W-1:0]  eff_s;
  logic [DW-1:0]     dly;
  logic [DW-1:0]     cnt;

  // zero settings count as a single cycle
  always_comb begin
    eff_f = (osc_freq == '0) ? FREQ_W'(1) : osc_freq;
    eff_s = (stable_cnt == '0) ? CNT_W'(1) : stable_cnt;
    dly   = DW'(eff_s) * DW'(eff_f);
    hit   = run && (cnt == dly - DW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run || hit) cnt <= '0;
    else                    cnt <= cnt + DW'(1);
  end

  // stage window restarts from zero after each expiry (R3)
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == '0));
endmodule

// File: rtl/pd_rst_pulse.sv
module pd_rst_pulse #(
  parameter int RST_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic fin
);
  localparam int PW = (RST_W > 1) ? $clog2(RST_W + 1) : 1;

  logic [PW-1:0] cnt;

  assign fin = active && (cnt == PW'(RST_W - 1));

  always_ff @(posedge clk) begin
    if (rst || !active || fin) cnt <= '0;
    else                       cnt <= cnt + PW'(1);
  end

  // pulse counter stays inside the programmed width (R6)
  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt < PW'(RST_W));
endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq
  import pd_wake_pkg::*;
#(
  parameter int N_MEM  = 4,
  parameter int N_MOD  = 4,
  parameter int FREQ_W = 4,
  parameter int CNT_W  = 8,
  parameter int RST_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_req,
  input  logic              pwr_down_req,
  input  logic              mode_simul,
  input  logic [FREQ_W-1:0] osc_freq,
  input  logic [CNT_W-1:0]  stable_cnt,
  input  logic [N_MOD-1:0]  retain,
  output logic              sw_small_en,
  output logic              sw_large_en,
  output logic [N_MEM-1:0]  mem_en,
  output logic [N_MOD-1:0]  mod_rst,
  output logic              done
);
  localparam int IW = (N_MEM > 1) ? $clog2(N_MEM) : 1;

  pwr_state_t       state, state_n;
  logic             mode_q;
  logic [IW-1:0]    mem_idx, mem_idx_n;
  logic [N_MEM-1:0] mem_n;
  logic             stage_run, stage_hit, pulse_fin;

  assign stage_run = (state == PS_SW1) || (state == PS_SW2) || (state == PS_MEM);

  pd_stage_timer #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .run(stage_run),
    .osc_freq(osc_freq), .stable_cnt(stable_cnt), .hit(stage_hit)
  );

  pd_rst_pulse #(.RST_W(RST_W)) pulse_i (
    .clk(clk), .rst(rst), .active(state == PS_RST), .fin(pulse_fin)
  );

  always_comb begin
    state_n   = state;
    mem_idx_n = mem_idx;
    mem_n     = mem_en;
    unique case (state)
      PS_OFF: if (wake_req) begin
        state_n   = PS_SW1;
        mem_idx_n = '0;
        mem_n     = mode_simul ? {N_MEM{1'b1}} : '0;
      end
      PS_SW1: if (stage_hit) state_n = PS_SW2;
      PS_SW2: if (stage_hit) state_n = mode_q ? PS_RST : PS_MEM;
      PS_MEM: if (stage_hit) begin
        mem_n     = (mem_en << 1) | N_MEM'(1);
        mem_idx_n = mem_idx + IW'(1);
        if (mem_idx == IW'(N_MEM - 1)) state_n = PS_RST;
      end
      PS_RST: if (pulse_fin) state_n = PS_ON;
      PS_ON: if (pwr_down_req) begin
        state_n = PS_OFF;
        mem_n   = '0;
      end
      default: state_n = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PS_OFF;
      mode_q      <= 1'b0;
      mem_idx     <= '0;
      mem_en      <= '0;
      sw_small_en <= 1'b0;
      sw_large_en <= 1'b0;
      mod_rst     <= '0;
      done        <= 1'b0;
    end else begin
      state       <= state_n;
      mem_idx     <= mem_idx_n;
      mem_en      <= mem_n;
      if (state == PS_OFF && wake_req) mode_q <= mode_simul;
      sw_small_en <= (state_n != PS_OFF);
      sw_large_en <= (state_n != PS_OFF) && (state_n != PS_SW1);
      mod_rst     <= (state_n == PS_RST) ? ~retain : '0;
      done        <= (state_n == PS_ON);
    end
  end

  p_large_needs_small_r2: assert property (@(posedge clk) disable iff (rst)
    sw_large_en |-> sw_small_en);

  p_mem_thermo_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_en & (mem_en + N_MEM'(1))) == '0);

  p_mem_one_step_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_en) != '0 && mem_en != '0 && mem_en != $past(mem_en))
      |-> (mem_en == (($past(mem_en) << 1) | N_MEM'(1))));

  p_retain_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (mod_rst & $past(retain)) == '0);

  p_done_full_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (sw_small_en && sw_large_en && (&mem_en) && mod_rst == '0));

  p_down_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (done && pwr_down_req) |=> (!sw_small_en && !sw_large_en && mem_en == '0 && !done));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_small_en && !done) |=> sw_small_en);
endmodule

// File: tb/pd_wake_seq_tb_top.sv
module pd_wake_seq_tb_top;
  localparam int NM = 4;
  localparam int NR = 4;
  localparam int RW = 4;
  localparam int NV = 6;

  // {mode, freq[4], stable[8], retain[4], disturb, exp_latency[8], exp_rst[4]}
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 4'd1, 8'd1, 4'b0000, 1'b0, 8'd10, 4'b1111},
    {1'b0, 4'd2, 8'd3, 4'b1010, 1'b1, 8'd40, 4'b0101},
    {1'b1, 4'd3, 8'd2, 4'b0001, 1'b0, 8'd16, 4'b1110},
    {1'b0, 4'd0, 8'd0, 4'b1111, 1'b0, 8'd10, 4'b0000},
    {1'b1, 4'd0, 8'd5, 4'b0110, 1'b1, 8'd14, 4'b1001},
    {1'b0, 4'd4, 8'd1, 4'b1000, 1'b0, 8'd28, 4'b0111}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_req = 1'b0;
  logic pwr_down_req = 1'b0;
  logic mode_simul = 1'b0;
  logic [3:0] osc_freq = '0;
  logic [7:0] stable_cnt = '0;
  logic [NR-1:0] retain = '0;
  logic sw_small_en, sw_large_en, done;
  logic [NM-1:0] mem_en;
  logic [NR-1:0] mod_rst;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  pd_wake_seq dut_i (
    .clk(clk), .rst(rst), .wake_req(wake_req), .pwr_down_req(pwr_down_req),
    .mode_simul(mode_simul), .osc_freq(osc_freq), .stable_cnt(stable_cnt),
    .retain(retain), .sw_small_en(sw_small_en), .sw_large_en(sw_large_en),
    .mem_en(mem_en), .mod_rst(mod_rst), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] all_out();
    return {19'd0, sw_small_en, sw_large_en, mem_en, mod_rst, done};
  endfunction

  task automatic run_vec(input int k);
    logic [29:0] v;
    int d, p, t, ms;
    v = VEC[k];
    d = ((v[28:25] == 0) ? 1 : int'(v[28:25])) * ((v[24:17] == 0) ? 1 : int'(v[24:17]));
    p = v[29] ? 2 * d : (2 + NM) * d;
    t = int'(v[11:4]);
    mode_simul = v[29];
    osc_freq   = v[28:25];
    stable_cnt = v[24:17];
    retain     = v[16:13];
    wake_req   = 1'b1;
    @(negedge clk);
    wake_req   = 1'b0;
    for (int j = 0; j <= t + 1; j++) begin
      chk("R2 sw_small", {31'd0, sw_small_en}, 32'd1);
      chk("R3 sw_large", {31'd0, sw_large_en}, {31'd0, (j >= d)});
      if (v[29]) chk("R5 mem_en", {28'd0, mem_en}, 32'hF);
      else begin
        ms = (j < 2 * d) ? 0 : (j - 2 * d) / d;
        if (ms > NM) ms = NM;
        chk("R4 mem_en", {28'd0, mem_en}, (32'd1 << ms) - 32'd1);
      end
      chk("R6 mod_rst", {28'd0, mod_rst}, (j >= p && j < t) ? {28'd0, v[3:0]} : 32'd0);
      chk(v[12] ? "R9 done timing" : "R7 done", {31'd0, done}, {31'd0, (j >= t)});
      if (v[12] && j == 3) begin
        wake_req = 1'b1;
        pwr_down_req = 1'b1;
      end else begin
        wake_req = 1'b0;
        pwr_down_req = 1'b0;
      end
      @(negedge clk);
    end
    pwr_down_req = 1'b1;
    @(negedge clk);
    pwr_down_req = 1'b0;
    chk("R8 power down", all_out(), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", all_out(), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle", all_out(), 32'd0);

    for (int k = 0; k < NV; k++) run_vec(k);

    // reset in the middle of a sequence
    mode_simul = 1'b1; osc_freq = 4'd2; stable_cnt = 8'd4;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 mem with logic", {28'd0, mem_en}, 32'hF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-sequence reset", all_out(), 32'd0);

    // wake while on is ignored
    run_vec(0);
    mode_simul = 1'b0; osc_freq = 4'd1; stable_cnt = 8'd1; retain = '0;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (12) @(negedge clk);
    chk("R7 done reached", {31'd0, done}, 32'd1);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk("R9 wake in on", all_out(), {19'd0, 1'b1, 1'b1, 4'hF, 4'h0, 1'b1});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL R7 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule